// File: doc/BRIEF.md
# Slotted Ring Fair-Share Access Controller

This block is the per-node access controller for one wavelength of a time-slotted ring. Each clock one slot header passes the node. The header holds a busy bit and a busy-address field. The controller decides whether the local queue may fill that slot, and it rewrites the header on its way downstream. A node may send up to `WINDOW` packets per fairness cycle. While it still has quota left and packets waiting, it is active and writes its own identity into the busy-address field of every slot that passes.

When a node has gone inactive and then sees its own identity come back in the busy-address field, no other node has claimed a slot since, so every node has finished its share. That node then launches a cycle reset onto the control path. A reset arriving from upstream reloads the quota and is passed on once. When the reset has gone all the way round to the node that launched it, that node absorbs it.

The header path is combinational, so the rewritten header leaves in the same cycle as the incoming one. The quota counter and a "reset pending" flag are the only state.

Top module: `ring_fair_mac`

## Requirements
- R1: After `rst_n` is released the quota equals `WINDOW` and no reset is pending. `active` is then 1 exactly when `q_nempty` is 1.
- R2: `tx_strobe` is 1 only when the node is active and `in_busy` is 0. In that case `out_busy` is 1. In every other case `out_busy` equals `in_busy`.
- R3: While active, `out_addr` equals `node_id` in every slot, whether or not the node transmits into it.
- R4: While inactive, `out_addr` equals `in_addr`.
- R5: Each transmission lowers the quota by one. After `WINDOW` transmissions with no reload, `active` is 0 even when `q_nempty` is 1.
- R6: When the node is inactive, `reset_in` is 0, no reset is pending, and `in_addr` equals `node_id`, the block raises `reset_out` for that cycle. The quota then reloads to `WINDOW` for the next cycle and the reset is marked pending. While the reset is pending, no further launch happens.
- R7: A `reset_in` pulse that arrives while no reset is pending raises `reset_out` in the same cycle. It also reloads the quota in that same cycle, so a node with a queued packet is active and may transmit into that slot.
- R8: A `reset_in` pulse that arrives while a reset is pending clears the pending flag. It gives no `reset_out` pulse and leaves the quota unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one header per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | ADDR_W | This node's ring address |
| in_busy | input | 1 | Busy bit of the incoming slot |
| in_addr | input | ADDR_W | Busy-address field of the incoming slot |
| q_nempty | input | 1 | Local queue holds a packet |
| reset_in | input | 1 | Cycle-reset pulse from the control path |
| out_busy | output | 1 | Busy bit sent downstream |
| out_addr | output | ADDR_W | Busy-address field sent downstream |
| tx_strobe | output | 1 | Local packet placed in this slot |
| reset_out | output | 1 | Cycle-reset pulse sent onward |
| active | output | 1 | Node holds quota and has a packet |

## Verification
The header outputs, `tx_strobe`, `reset_out` and `active` are due in the same cycle as the header and reset inputs that cause them. The bench drives inputs on the falling edge and samples them 1 ns later. A quota change or a change to the pending flag shows first in the cycle after the rising edge that stores it, so the bench's arithmetic model updates just after each rising edge. Directed phases drain the quota, launch a reset and absorb it. A long sweep over every combination of header, queue and reset inputs then compares all outputs against the model in every cycle.

// File: rtl/ring_fair_mac.sv
module ring_fair_mac #(
  parameter int ADDR_W = 4,
  parameter int WINDOW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] node_id,
  input  logic              in_busy,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              q_nempty,
  input  logic              reset_in,
  output logic              out_busy,
  output logic [ADDR_W-1:0] out_addr,
  output logic              tx_strobe,
  output logic              reset_out,
  output logic              active
);
  localparam int QW = $clog2(WINDOW + 1);
  localparam logic [QW-1:0] QFULL = QW'(WINDOW);

  logic [QW-1:0] quota;
  logic          pending;

  wire           fwd    = reset_in && !pending;
  wire           absorb = reset_in && pending;
  wire [QW-1:0]  q_eff  = fwd ? QFULL : quota;
  wire           launch = !active && !reset_in && !pending && (in_addr == node_id);

  assign active    = (q_eff != '0) && q_nempty;
  assign tx_strobe = active && !in_busy;
  assign out_busy  = in_busy || tx_strobe;
  assign out_addr  = active ? node_id : in_addr;
  assign reset_out = fwd || launch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quota   <= QFULL;
      pending <= 1'b0;
    end else begin
      if (launch)          quota <= QFULL;
      else if (tx_strobe)  quota <= q_eff - 1'b1;
      else                 quota <= q_eff;
      if (launch)          pending <= 1'b1;
      else if (absorb)     pending <= 1'b0;
    end
  end

  logic [QW:0] sent;
  always_ff @(posedge clk) begin
    if (!rst_n)                sent <= '0;
    else if (reset_out)        sent <= (QW+1)'(tx_strobe);
    else if (tx_strobe)        sent <= sent + 1'b1;
  end

  a_r2_tx_into_free: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |-> (!in_busy && out_busy && q_nempty));
  a_r3_mark_own: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> out_addr == node_id);
  a_r4_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (out_addr == in_addr && out_busy == in_busy));
  a_r5_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sent <= (QW+1)'(WINDOW));
  a_r6_single_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_out && !reset_in) |=> !(reset_out && !reset_in));
  a_r8_absorb_own: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_out && !reset_in) |=> (reset_in |-> !reset_out));
endmodule

// File: tb/ring_fair_mac_tb.sv
module ring_fair_mac_tb;
  localparam int AW = 4;
  localparam int W  = 3;
  localparam logic [AW-1:0] ID = 4'd5;

  logic clk = 0, rst_n = 0;
  logic in_busy = 0, q_nempty = 0, reset_in = 0;
  logic [AW-1:0] in_addr = 0;
  logic out_busy, tx_strobe, reset_out, active;
  logic [AW-1:0] out_addr;

  always #2.5 clk = ~clk;

  ring_fair_mac #(.ADDR_W(AW), .WINDOW(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .node_id(ID), .in_busy(in_busy), .in_addr(in_addr),
    .q_nempty(q_nempty), .reset_in(reset_in), .out_busy(out_busy), .out_addr(out_addr),
    .tx_strobe(tx_strobe), .reset_out(reset_out), .active(active));

  int checks = 0, fails = 0;
  int mq = W;
  bit mpend = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit b, input logic [AW-1:0] a, input bit qn, input bit ri);
    bit fwd, ab, act, tx, la;
    int qe;
    @(negedge clk);
    in_busy = b; in_addr = a; q_nempty = qn; reset_in = ri;
    #1;
    fwd = ri && !mpend; ab = ri && mpend;
    qe  = fwd ? W : mq;
    act = (qe != 0) && qn;
    tx  = act && !b;
    la  = !act && !ri && !mpend && (a == ID);
    chk(qe == W ? "R1/R7 active" : "R5 active", active, act);
    chk("R2 tx_strobe", tx_strobe, tx);
    chk("R2 out_busy", out_busy, b | tx);
    chk(act ? "R3 out_addr" : "R4 out_addr", out_addr, act ? ID : a);
    chk(ri ? (mpend ? "R8 reset_out" : "R7 reset_out") : "R6 reset_out", reset_out, fwd | la);
    @(posedge clk);
    if (la) begin mq = W; mpend = 1; end
    else mq = qe - (tx ? 1 : 0);
    if (ab) mpend = 0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    step(0, 0, 0, 0);
    step(0, 0, 1, 0);
    // R3: active on busy slot, marks without sending
    step(1, 2, 1, 0);
    // R5 drain the window
    step(0, 1, 1, 0); step(0, 1, 1, 0); step(0, 1, 1, 0);
    step(0, 1, 1, 0);
    // R6 launch on own address, then no relaunch while pending
    step(1, ID, 0, 0);
    step(1, ID, 0, 0);
    // R8 own reset returns
    step(0, 0, 1, 1);
    // drain and R7 forwarded reset used in same slot
    step(0, 0, 1, 0); step(0, 0, 1, 0);
    step(0, 0, 1, 1);
    // near-exhaustive sweep over input combinations
    lf = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0], (lf[3:1] == 0) ? ID : lf[7:4], lf[8] | lf[9], (lf[12:10] == 0));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule